// File: doc/BRIEF.md
# Character RAM Write Controller

This block loads programmable character patterns into the upper half of a character RAM. A processor writes three registers in a small I/O window: a pattern byte, the low eight bits of a pattern offset, and a control byte. The control register write is the trigger. A pattern store is committed only when that write takes the arm bit from 0 to 1. The offset is the address register extended by two control bits. The stored byte is either the pattern byte register or a byte copied from the font ROM, which lets software seed a pattern from the built-in glyphs.

The font ROM is external and synchronous, with one cycle of read latency. The block drives the ROM address while the control write is on the bus. It issues the character RAM write one cycle later, when the ROM byte has arrived. The control register value is presented on an output, because the display path uses its bits to choose between pattern sources. The processor write port has no back-pressure: every strobe is taken in the cycle it is presented. There is no ready signal, and the character RAM write port is assumed always able to accept. The block has no read path.

Top module: `chargen_loader`

## Requirements
- R1: On reset the pattern byte and address registers clear to 0x00 and the control register sets to 0xFF. No character RAM write is issued during or straight after reset.
- R2: A strobed write to BASE_ADDR+2 (0xE012 by default) loads the control register. The new value appears on `ctrl_q` in the cycle after the write.
- R3: A character RAM write pulse (`cram_we` high for exactly one cycle) is issued in the cycle after a control write, and only when control bit 4 was 0 before that write and is 1 in the written byte. Transitions 0->0, 1->1 and 1->0 of bit 4 issue no write.
- R4: The 10-bit pattern offset is the address register in bits 7:0 and the newly written control bits 1:0 in bits 9:8. It appears in `cram_addr[9:0]`.
- R5: `cram_addr[10]` is always 1 on a commit, so only the upper 1 KB of each 2 KB bank is written. With TWO_BANKS=1 (the default), `cram_addr[11]` equals the newly written control bit 2, giving 0xC00|offset when bit 2 is 1 and 0x400|offset when it is 0.
- R6: When the newly written control bit 5 is 0, the stored byte is the pattern byte register, which is loaded by a strobed write to BASE_ADDR (0xE010).
- R7: When the newly written control bit 5 is 1, the stored byte is the font ROM byte at ROM address 0x400|offset, independent of control bit 2. `font_addr` carries that address during the control write cycle.
- R8: Writes to any address other than BASE_ADDR..BASE_ADDR+2, and bus cycles without `cpu_wr`, change no register and issue no write.
- R9: Writes to the pattern byte register or the address register (BASE_ADDR+1, 0xE011) never issue a character RAM write by themselves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Processor write strobe, one cycle per write |
| cpu_addr | input | 16 | Processor byte address |
| cpu_wdata | input | 8 | Processor write data |
| font_addr | output | 11 | Font ROM read address, valid in the control write cycle |
| font_rdata | input | 8 | Font ROM data, one cycle after `font_addr` |
| cram_addr | output | 12 | Character RAM write address |
| cram_wdata | output | 8 | Character RAM write data |
| cram_we | output | 1 | Character RAM write enable, one-cycle pulse |
| ctrl_q | output | 8 | Current control register value |

## Verification
The control register shows its new value one edge after the strobe. A commit's `cram_we`, `cram_addr` and `cram_wdata` are valid in that same following cycle, because the font ROM has registered its byte at the capture edge. The bench drives each write between falling edges. It then samples all outputs at the very next falling edge, which is the single cycle where a pulse can exist. For writes that must not commit, it samples the enable at the same point. Ignored writes are shown harmless by a later commit that exposes the untouched register contents at the outputs.

// File: rtl/chargen_pkg.sv
package chargen_pkg;

  // Register selected by a processor bus cycle
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_ADDR = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  // Control byte field positions (the display path decodes the same byte)
  localparam int CTL_HI_LSB   = 0;  // offset bits 9:8
  localparam int CTL_HI_W     = 2;
  localparam int CTL_BANK_BIT = 2;  // upper bank select (two-bank variant)
  localparam int CTL_ARM_BIT  = 4;  // rising edge commits
  localparam int CTL_COPY_BIT = 5;  // source byte from font ROM

  // Register offsets from the window base
  localparam int OFS_DATA = 0;
  localparam int OFS_ADDR = 1;
  localparam int OFS_CTRL = 2;

endpackage

// File: rtl/chargen_decode.sv
module chargen_decode
  import chargen_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [15:0]     BASE_ADDR = 16'hE010
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(BASE_ADDR + OFS_DATA);
  localparam logic [ADDR_W-1:0] A_ADDR = ADDR_W'(BASE_ADDR + OFS_ADDR);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(BASE_ADDR + OFS_CTRL);

  always_comb begin
    sel = SEL_NONE;
    if (wr) begin
      if (addr == A_DATA)      sel = SEL_DATA;
      else if (addr == A_ADDR) sel = SEL_ADDR;
      else if (addr == A_CTRL) sel = SEL_CTRL;
    end
  end

endmodule

// File: rtl/chargen_regs.sv
module chargen_regs
  import chargen_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  reg_sel_e          sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] data_q,
  output logic [DATA_W-1:0] addr_q,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              arm
);

  localparam logic [DATA_W-1:0] CTRL_RST = '1;

  // Commit request: this control write takes the arm bit from 0 to 1
  assign arm = (sel == SEL_CTRL) && wdata[CTL_ARM_BIT] && !ctrl_q[CTL_ARM_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      addr_q <= '0;
      ctrl_q <= CTRL_RST;
    end else begin
      unique case (sel)
        SEL_DATA: data_q <= wdata;
        SEL_ADDR: addr_q <= wdata;
        SEL_CTRL: ctrl_q <= wdata;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/chargen_commit.sv
module chargen_commit
  import chargen_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int TWO_BANKS = 1,
  parameter int OFS_W     = DATA_W + CTL_HI_W,
  parameter int FONT_AW   = OFS_W + 1,
  parameter int CRAM_AW   = OFS_W + 1 + TWO_BANKS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm,
  input  logic [DATA_W-1:0]  ctrl_new,
  input  logic [DATA_W-1:0]  addr_q,
  input  logic [DATA_W-1:0]  data_q,
  output logic [FONT_AW-1:0] font_addr,
  input  logic [DATA_W-1:0]  font_rdata,
  output logic [CRAM_AW-1:0] cram_addr,
  output logic [DATA_W-1:0]  cram_wdata,
  output logic               cram_we
);

  logic [OFS_W-1:0]   offset;
  logic [CRAM_AW-1:0] target;
  logic               pend_copy;

  assign offset    = {ctrl_new[CTL_HI_LSB +: CTL_HI_W], addr_q};
  // The font source always sits in the upper half of the ROM
  assign font_addr = {1'b1, offset};

  generate
    if (TWO_BANKS != 0) begin : g_two_bank
      assign target = {ctrl_new[CTL_BANK_BIT], 1'b1, offset};
    end else begin : g_one_bank
      assign target = {1'b1, offset};
    end
  endgenerate

  // One stage: waits for the synchronous font ROM byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cram_we   <= 1'b0;
      cram_addr <= '0;
      pend_copy <= 1'b0;
    end else begin
      cram_we <= arm;
      if (arm) begin
        cram_addr <= target;
        pend_copy <= ctrl_new[CTL_COPY_BIT];
      end
    end
  end

  // The data register cannot change in the cycle after a control write
  assign cram_wdata = pend_copy ? font_rdata : data_q;

endmodule

// File: rtl/chargen_loader.sv
module chargen_loader
  import chargen_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter int          TWO_BANKS = 1,
  parameter logic [15:0] BASE_ADDR = 16'hE010,
  parameter int          OFS_W     = DATA_W + CTL_HI_W,
  parameter int          FONT_AW   = OFS_W + 1,
  parameter int          CRAM_AW   = OFS_W + 1 + TWO_BANKS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_wr,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  output logic [FONT_AW-1:0] font_addr,
  input  logic [DATA_W-1:0]  font_rdata,
  output logic [CRAM_AW-1:0] cram_addr,
  output logic [DATA_W-1:0]  cram_wdata,
  output logic               cram_we,
  output logic [DATA_W-1:0]  ctrl_q
);

  reg_sel_e          sel;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] addr_q;
  logic              arm;

  chargen_decode #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_decode (
    .wr   (cpu_wr),
    .addr (cpu_addr),
    .sel  (sel)
  );

  chargen_regs #(
    .DATA_W (DATA_W)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (sel),
    .wdata  (cpu_wdata),
    .data_q (data_q),
    .addr_q (addr_q),
    .ctrl_q (ctrl_q),
    .arm    (arm)
  );

  chargen_commit #(
    .DATA_W    (DATA_W),
    .TWO_BANKS (TWO_BANKS),
    .OFS_W     (OFS_W),
    .FONT_AW   (FONT_AW),
    .CRAM_AW   (CRAM_AW)
  ) u_commit (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm),
    .ctrl_new   (cpu_wdata),
    .addr_q     (addr_q),
    .data_q     (data_q),
    .font_addr  (font_addr),
    .font_rdata (font_rdata),
    .cram_addr  (cram_addr),
    .cram_wdata (cram_wdata),
    .cram_we    (cram_we)
  );

endmodule

// File: rtl/chargen_loader_chk.sv
module chargen_loader_chk #(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter int          TWO_BANKS = 1,
  parameter logic [15:0] BASE_ADDR = 16'hE010,
  parameter int          OFS_W     = 10,
  parameter int          FONT_AW   = 11,
  parameter int          CRAM_AW   = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_wr,
  input logic [ADDR_W-1:0]  cpu_addr,
  input logic [DATA_W-1:0]  cpu_wdata,
  input logic [FONT_AW-1:0] font_addr,
  input logic [DATA_W-1:0]  font_rdata,
  input logic [CRAM_AW-1:0] cram_addr,
  input logic [DATA_W-1:0]  cram_wdata,
  input logic               cram_we,
  input logic [DATA_W-1:0]  ctrl_q
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(BASE_ADDR + 16'd2);

  logic ctrl_wr;
  assign ctrl_wr = cpu_wr && (cpu_addr == A_CTRL);

  // R1: leaving reset, control is all ones and no write is pending
  a_r1_reset_state: assert property (@(posedge clk)
    $rose(rst_n) |-> (ctrl_q == '1) && !cram_we);

  // R3: a pulse follows only an arming control write
  a_r3_commit_cause: assert property (@(posedge clk) disable iff (!rst_n)
    cram_we |-> $past(ctrl_wr) && $past(cpu_wdata[4]) && !$past(ctrl_q[4]));

  // R3: the pulse lasts one cycle
  a_r3_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    cram_we |=> !cram_we);

  // R4: offset high bits come from the written control byte
  a_r4_offset_hi: assert property (@(posedge clk) disable iff (!rst_n)
    cram_we |-> cram_addr[OFS_W-1 -: 2] == $past(cpu_wdata[1:0]));

  // R5: upper half of the bank, bank chosen by bit 2
  generate
    if (TWO_BANKS != 0) begin : g_bank_chk
      a_r5_bank_select: assert property (@(posedge clk) disable iff (!rst_n)
        cram_we |-> cram_addr[OFS_W] && (cram_addr[OFS_W+1] == ctrl_q[2]));
    end else begin : g_half_chk
      a_r5_upper_half: assert property (@(posedge clk) disable iff (!rst_n)
        cram_we |-> cram_addr[OFS_W]);
    end
  endgenerate

  // R7: copy mode stores the ROM byte read at the matching address
  a_r7_copy_source: assert property (@(posedge clk) disable iff (!rst_n)
    (cram_we && ctrl_q[5]) |->
      (cram_wdata == font_rdata) && ($past(font_addr) == {1'b1, cram_addr[OFS_W-1:0]}));

  // R8: control changes only on a strobed control write
  a_r8_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(ctrl_q));

endmodule

bind chargen_loader chargen_loader_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .TWO_BANKS (TWO_BANKS),
  .BASE_ADDR (BASE_ADDR),
  .OFS_W     (OFS_W),
  .FONT_AW   (FONT_AW),
  .CRAM_AW   (CRAM_AW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_wr     (cpu_wr),
  .cpu_addr   (cpu_addr),
  .cpu_wdata  (cpu_wdata),
  .font_addr  (font_addr),
  .font_rdata (font_rdata),
  .cram_addr  (cram_addr),
  .cram_wdata (cram_wdata),
  .cram_we    (cram_we),
  .ctrl_q     (ctrl_q)
);

// File: tb/chargen_loader_bench.sv
module chargen_loader_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [10:0] font_addr;
  logic [7:0]  font_rdata = '0;
  logic [11:0] cram_addr;
  logic [7:0]  cram_wdata;
  logic        cram_we;
  logic [7:0]  ctrl_q;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 0;

  always #2 clk = ~clk;

  chargen_loader u_chargen_loader (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_wr     (cpu_wr),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .font_addr  (font_addr),
    .font_rdata (font_rdata),
    .cram_addr  (cram_addr),
    .cram_wdata (cram_wdata),
    .cram_we    (cram_we),
    .ctrl_q     (ctrl_q)
  );

  // Font ROM model: synchronous, one cycle latency
  function automatic logic [7:0] font_byte(logic [10:0] a);
    return (a[7:0] + 8'h5A) ^ {5'b0, a[10:8]};
  endfunction

  always_ff @(posedge clk) font_rdata <= font_byte(font_addr);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  // {data, addr, ctrl_pre, ctrl, exp_we, exp_cram_addr}
  localparam logic [44:0] VEC [8] = '{
    {8'h3C, 8'h12, 8'h00, 8'h10, 1'b1, 12'h412},
    {8'hA5, 8'hFF, 8'h00, 8'h13, 1'b1, 12'h7FF},
    {8'h77, 8'h40, 8'h00, 8'h16, 1'b1, 12'hE40},
    {8'h11, 8'h08, 8'h00, 8'h31, 1'b1, 12'h508},
    {8'h22, 8'h80, 8'h00, 8'h36, 1'b1, 12'hE80},
    {8'h99, 8'h01, 8'h10, 8'h10, 1'b0, 12'h000},
    {8'h99, 8'h01, 8'h00, 8'h00, 1'b0, 12'h000},
    {8'h99, 8'h01, 8'h10, 8'h00, 1'b0, 12'h000}
  };

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ctrl in reset", {24'b0, ctrl_q}, 32'hFF);
    check("R1 no write in reset", {31'b0, cram_we}, 0);
    rst_n = 1'b1;
    idle();
    check("R1 ctrl after reset", {24'b0, ctrl_q}, 32'hFF);
    check("R1 no write after reset", {31'b0, cram_we}, 0);

    // R3: reset control has bit 4 set, so 1->1 does not commit
    bus_wr(16'hE012, 8'h10);
    check("R3 no commit from reset value", {31'b0, cram_we}, 0);
    check("R2 ctrl loaded", {24'b0, ctrl_q}, 32'h10);

    // R1: cleared data/address seen through a commit
    bus_wr(16'hE012, 8'h00);
    bus_wr(16'hE012, 8'h10);
    check("R3 commit pulse", {31'b0, cram_we}, 1);
    check("R1 cleared address reg", {20'b0, cram_addr}, 32'h400);
    check("R1 cleared data reg", {24'b0, cram_wdata}, 0);
    idle();
    check("R3 pulse one cycle", {31'b0, cram_we}, 0);

    // Table walk
    for (int i = 0; i < 8; i++) begin
      logic [7:0]  d, a, pre, c;
      logic        ewe;
      logic [11:0] ead;
      logic [7:0]  edat;
      {d, a, pre, c, ewe, ead} = VEC[i];
      bus_wr(16'hE010, d);
      bus_wr(16'hE011, a);
      bus_wr(16'hE012, pre);
      idle();
      bus_wr(16'hE012, c);
      edat = c[5] ? font_byte({1'b1, c[1:0], a}) : d;
      check($sformatf("R3 vector %0d pulse", i), {31'b0, cram_we}, {31'b0, ewe});
      check($sformatf("R2 vector %0d ctrl", i), {24'b0, ctrl_q}, {24'b0, c});
      if (ewe) begin
        check($sformatf("R4 R5 vector %0d address", i), {20'b0, cram_addr}, {20'b0, ead});
        check($sformatf("%s vector %0d data", c[5] ? "R7" : "R6", i),
              {24'b0, cram_wdata}, {24'b0, edat});
      end
    end

    // R9: data and address writes alone never commit
    bus_wr(16'hE010, 8'h5A);
    check("R9 data write no commit", {31'b0, cram_we}, 0);
    bus_wr(16'hE011, 8'h33);
    check("R9 addr write no commit", {31'b0, cram_we}, 0);

    // R8: foreign addresses and unstrobed cycles are ignored (ctrl is 0x00)
    bus_wr(16'hA012, 8'h10);
    check("R8 alias ctrl no commit", {31'b0, cram_we}, 0);
    check("R8 alias ctrl unchanged", {24'b0, ctrl_q}, 0);
    bus_wr(16'hE013, 8'h10);
    check("R8 E013 no commit", {31'b0, cram_we}, 0);
    @(negedge clk);
    cpu_wr = 1'b0; cpu_addr = 16'hE012; cpu_wdata = 8'h10;
    @(negedge clk);
    check("R8 unstrobed no commit", {31'b0, cram_we}, 0);
    check("R8 unstrobed ctrl unchanged", {24'b0, ctrl_q}, 0);
    bus_wr(16'hA010, 8'hEE);
    bus_wr(16'hA011, 8'hEE);
    bus_wr(16'hE00F, 8'hEE);
    bus_wr(16'hE012, 8'h10);
    check("R8 commit after ignored writes", {31'b0, cram_we}, 1);
    check("R8 address reg untouched", {20'b0, cram_addr}, 32'h433);
    check("R8 data reg untouched", {24'b0, cram_wdata}, 32'h5A);

    // R5: bank bit clear with copy keeps 0x400 target, ROM still at 0x400|offset
    bus_wr(16'hE011, 8'h7E);
    bus_wr(16'hE012, 8'h00);
    bus_wr(16'hE012, 8'h33);
    check("R5 lower bank address", {20'b0, cram_addr}, 32'h77E);
    check("R7 copy byte", {24'b0, cram_wdata}, {24'b0, font_byte(11'h77E)});

    // R1: reset mid-run restores control
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 ctrl after second reset", {24'b0, ctrl_q}, 32'hFF);
    rst_n = 1'b1;
    idle();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule